// File: doc/BRIEF.md
# Serial Flash Write-Enable Guard

This block is the receive side of a serial flash device's command port, reduced to the part that guards against accidental writes. The chip-select line frames each instruction. While a frame is open, an 8-bit opcode is shifted in on the rising edge of the serial clock. A write-enable latch decides whether program and erase instructions may start.

Host opcodes arm and disarm the latch. An accepted program or erase instruction marks the device busy. A completion pulse on `op_done` then ends the operation and disarms the latch. A device reset opcode, or a system reset, also disarms the latch. The block reports the latch, the busy flag and a status byte built from both. It also gives a one-cycle strobe for each accepted instruction and a one-cycle strobe for each refused instruction.

The serial inputs are brought into the system clock domain through two-flop synchronisers, and all edges are found there. The control core is a three-state machine:
- `ST_LOCKED`: latch 0, idle.
- `ST_ARMED`: latch 1, idle.
- `ST_BUSY`: latch 1, operation running.

The transitions are named as follows:
- `arm`: LOCKED to ARMED on opcode 06h.
- `disarm`: ARMED to LOCKED on 04h or FFh.
- `launch`: ARMED to BUSY on a gated opcode.
- `finish`: BUSY to LOCKED on `op_done`.
- `abort`: BUSY to LOCKED on FFh.

Every other case holds the state.

Top module: `spi_wel_ctrl`

## Requirements
- R1: After system reset, `wel`, `busy`, `cmd_ok` and `cmd_rej` are 0 and `status` reads 00h.
- R2: A complete frame carrying opcode 06h sets `wel` to 1 and pulses `cmd_ok` once.
- R3: A complete frame carrying opcode 04h clears `wel` to 0 and pulses `cmd_ok` once.
- R4: Bits are taken MSB first on rising edges of `sck` while `cs_n` is low, and the command acts when `cs_n` goes high. This works whether `sck` idles low (mode 0) or high (mode 3).
- R5: A frame with a rising-edge count other than 8 is discarded: no strobe and no change of `wel` or `busy`.
- R6: The gated opcodes 02h, 32h and D8h are refused while `wel` is 0: `cmd_rej` pulses once and `busy` stays 0.
- R7: A gated opcode while `wel` is 1 and idle pulses `cmd_ok` and sets `busy` to 1, with `wel` held at 1.
- R8: A high `op_done` while busy clears `busy` and `wel` together on the next clock edge. `op_done` while not busy changes nothing.
- R9: Opcode FFh is accepted in every state (`cmd_ok`) and clears both `wel` and `busy`.
- R10: While busy, the opcodes 06h, 04h, 02h, 32h and D8h pulse `cmd_rej` and change nothing. `cmd_ok` and `cmd_rej` are never high together.
- R11: `status` carries `busy` in bit 0 and `wel` in bit 1; bits 7 to 2 read 0.
- R12: `so_oe` stays 0, so the serial output is never driven.
- R13: Any other opcode is ignored: no strobe and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in |
| op_done | input | 1 | Program or erase completion pulse |
| so_oe | output | 1 | Serial output enable, held 0 |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Program or erase in progress |
| status | output | 8 | Status byte: bit 1 latch, bit 0 busy |
| cmd_ok | output | 1 | One-cycle accepted-command strobe |
| cmd_rej | output | 1 | One-cycle refused-command strobe |

## Verification
A frame's result appears on the third rising `clk` edge after `cs_n` goes high. Two edges pass through the synchroniser, and the third registers the state and the strobe together. The bench therefore waits twelve system cycles after closing each frame before it samples. It sees the one-cycle strobes through counters that sample every falling edge, so each check compares counter deltas rather than catching the pulse itself. The `op_done` result is due one edge after the pulse, so `wel` and `busy` are checked at the very next falling edge.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;

    localparam int OPW = 8;

    localparam logic [OPW-1:0] OPC_ARM    = 8'h06;
    localparam logic [OPW-1:0] OPC_DISARM = 8'h04;
    localparam logic [OPW-1:0] OPC_PROG   = 8'h02;
    localparam logic [OPW-1:0] OPC_QPROG  = 8'h32;
    localparam logic [OPW-1:0] OPC_ERASE  = 8'hD8;
    localparam logic [OPW-1:0] OPC_RESET  = 8'hFF;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_BUSY   = 2'd2
    } wel_state_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_ARM,
        CL_DISARM,
        CL_GATED,
        CL_RESET
    } op_class_e;

    function automatic op_class_e classify(input logic [OPW-1:0] op);
        op_class_e c;
        case (op)
            OPC_ARM:                        c = CL_ARM;
            OPC_DISARM:                     c = CL_DISARM;
            OPC_PROG, OPC_QPROG, OPC_ERASE: c = CL_GATED;
            OPC_RESET:                      c = CL_RESET;
            default:                        c = CL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[0] <= RST_VAL;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[i] <= RST_VAL;
                    else        stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_wel_pkg::*;
#(
    parameter int BITS = OPW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck_s,
    input  logic            cs_n_s,
    input  logic            mosi_s,
    output logic            frame_valid,
    output logic [BITS-1:0] frame_op
);
    localparam int CNT_MAX = BITS + 1;
    localparam int CW = $clog2(CNT_MAX + 1);

    logic          sck_q;
    logic          cs_q;
    logic [CW-1:0] cnt;
    logic [BITS-1:0] shreg;
    logic          sck_rise;
    logic          cs_rise;

    assign sck_rise = sck_s & ~sck_q & ~cs_n_s;
    assign cs_rise  = cs_n_s & ~cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
            if (cs_n_s) begin
                cnt <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[BITS-2:0], mosi_s};
                if (cnt != CW'(CNT_MAX)) cnt <= cnt + 1'b1;
            end
        end
    end

    assign frame_valid = cs_rise && (cnt == CW'(BITS));
    assign frame_op    = shreg;
endmodule

// File: rtl/wel_fsm.sv
module wel_fsm
    import spi_wel_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_valid,
    input  logic [OPW-1:0] frame_op,
    input  logic           op_done,
    output wel_state_e     state,
    output logic           cmd_ok,
    output logic           cmd_rej
);
    wel_state_e nxt;
    logic       ok_d;
    logic       rej_d;
    op_class_e  cls;

    assign cls = classify(frame_op);

    always_comb begin
        nxt   = state;
        ok_d  = 1'b0;
        rej_d = 1'b0;
        unique case (state)
            ST_LOCKED: begin
                if (frame_valid) begin
                    case (cls)
                        CL_ARM:              begin nxt = ST_ARMED; ok_d = 1'b1; end
                        CL_DISARM, CL_RESET: ok_d  = 1'b1;
                        CL_GATED:            rej_d = 1'b1;
                        default:             ;
                    endcase
                end
            end
            ST_ARMED: begin
                if (frame_valid) begin
                    case (cls)
                        CL_ARM:              ok_d = 1'b1;
                        CL_DISARM, CL_RESET: begin nxt = ST_LOCKED; ok_d = 1'b1; end
                        CL_GATED:            begin nxt = ST_BUSY;   ok_d = 1'b1; end
                        default:             ;
                    endcase
                end
            end
            ST_BUSY: begin
                if (op_done) nxt = ST_LOCKED;
                if (frame_valid) begin
                    if (cls == CL_RESET) begin
                        nxt  = ST_LOCKED;
                        ok_d = 1'b1;
                    end else if (cls != CL_NONE) begin
                        rej_d = 1'b1;
                    end
                end
            end
            default: nxt = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_ok  <= 1'b0;
            cmd_rej <= 1'b0;
        end else begin
            cmd_ok  <= ok_d;
            cmd_rej <= rej_d;
        end
    end
endmodule

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl
    import spi_wel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       op_done,
    output logic       so_oe,
    output logic       wel,
    output logic       busy,
    output logic [7:0] status,
    output logic       cmd_ok,
    output logic       cmd_rej
);
    logic [2:0]     sync_q;
    logic           frame_valid;
    logic [OPW-1:0] frame_op;
    wel_state_e     state;

    spi_in_sync #(
        .W(3),
        .STAGES(SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, sck, mosi}),
        .q    (sync_q)
    );

    spi_frame_rx #(.BITS(OPW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (sync_q[1]),
        .cs_n_s     (sync_q[2]),
        .mosi_s     (sync_q[0]),
        .frame_valid(frame_valid),
        .frame_op   (frame_op)
    );

    wel_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_valid(frame_valid),
        .frame_op   (frame_op),
        .op_done    (op_done),
        .state      (state),
        .cmd_ok     (cmd_ok),
        .cmd_rej    (cmd_rej)
    );

    assign wel    = (state != ST_LOCKED);
    assign busy   = (state == ST_BUSY);
    assign status = {6'b0, wel, busy};
    assign so_oe  = 1'b0;
endmodule

// File: rtl/spi_wel_chk.sv
module spi_wel_chk (
    input logic clk,
    input logic rst_n,
    input logic op_done,
    input logic wel,
    input logic busy,
    input logic cmd_ok,
    input logic cmd_rej
);
    assert_busy_needs_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wel);

    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done) |=> (!busy && !wel));

    assert_launch_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wel) && cmd_ok));

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ok && cmd_rej));

    assert_arm_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> cmd_ok);
endmodule

bind spi_wel_ctrl spi_wel_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_done(op_done),
    .wel    (wel),
    .busy   (busy),
    .cmd_ok (cmd_ok),
    .cmd_rej(cmd_rej)
);

// File: tb/spi_wel_ctrl_test.sv
module spi_wel_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic op_done = 1'b0;
    logic so_oe, wel, busy, cmd_ok, cmd_rej;
    logic [7:0] status;

    int total = 0;
    int bad = 0;
    int n_ok = 0;
    int n_rej = 0;
    bit oe_seen = 1'b0;

    always #4 clk = ~clk;

    spi_wel_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .op_done(op_done), .so_oe(so_oe), .wel(wel), .busy(busy),
        .status(status), .cmd_ok(cmd_ok), .cmd_rej(cmd_rej)
    );

    always @(negedge clk) begin
        if (cmd_ok)  n_ok++;
        if (cmd_rej) n_rej++;
        if (so_oe)   oe_seen = 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (6) @(negedge clk);
    endtask

    // Sends nbits MSB first; bits past the 8th are zero.
    task automatic send(input logic [7:0] op, input int nbits, input bit mode3);
        @(negedge clk);
        sck = mode3;
        half();
        cs_n = 1'b0;
        half();
        for (int i = 0; i < nbits; i++) begin
            sck  = 1'b0;
            mosi = (i < 8) ? op[7-i] : 1'b0;
            half();
            sck = 1'b1;
            half();
        end
        if (!mode3) begin
            sck = 1'b0;
            half();
        end
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 wel", wel, 0);
        chk("R1 busy", busy, 0);
        chk("R1 status", status, 8'h00);
        chk("R1 strobes", {cmd_ok, cmd_rej}, 0);
        chk("R12 so_oe", so_oe, 0);
    endtask

    task automatic t_set_clear();
        int o;
        o = n_ok;
        send(8'h06, 8, 1'b0);
        chk("R2 wel set", wel, 1);
        chk("R2 ok pulse", n_ok - o, 1);
        chk("R11 status armed", status, 8'h02);
        o = n_ok;
        send(8'h04, 8, 1'b1);
        chk("R3 wel clear mode3", wel, 0);
        chk("R3 ok pulse", n_ok - o, 1);
        send(8'h06, 8, 1'b1);
        chk("R4 mode3 set", wel, 1);
        send(8'h20, 8, 1'b0);
        send(8'h04, 8, 1'b0);
        chk("R4 mode0 clear", wel, 0);
        send(8'h60, 8, 1'b0);
        chk("R4 msb first: 60h not arm", wel, 0);
    endtask

    task automatic t_short_long();
        int o, r;
        send(8'h06, 8, 1'b0);
        o = n_ok; r = n_rej;
        send(8'h04, 7, 1'b0);
        chk("R5 7-bit frame wel", wel, 1);
        send(8'h04, 9, 1'b1);
        chk("R5 9-bit frame wel", wel, 1);
        chk("R5 no strobes", (n_ok - o) + (n_rej - r), 0);
    endtask

    task automatic t_unknown();
        int o, r;
        o = n_ok; r = n_rej;
        send(8'h9F, 8, 1'b0);
        chk("R13 wel kept", wel, 1);
        chk("R13 no strobes", (n_ok - o) + (n_rej - r), 0);
    endtask

    task automatic t_gate_locked();
        int r;
        send(8'h04, 8, 1'b0);
        r = n_rej;
        send(8'h02, 8, 1'b0);
        chk("R6 prog refused busy", busy, 0);
        send(8'hD8, 8, 1'b1);
        chk("R6 erase refused busy", busy, 0);
        chk("R6 rej pulses", n_rej - r, 2);
    endtask

    task automatic t_gate_armed();
        int o, r;
        send(8'h06, 8, 1'b0);
        o = n_ok;
        send(8'h32, 8, 1'b0);
        chk("R7 busy set", busy, 1);
        chk("R7 wel held", wel, 1);
        chk("R7 ok pulse", n_ok - o, 1);
        chk("R11 status busy", status, 8'h03);
        r = n_rej;
        send(8'h04, 8, 1'b0);
        chk("R10 disarm refused while busy", wel, 1);
        chk("R10 rej pulse", n_rej - r, 1);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        chk("R8 busy cleared", busy, 0);
        chk("R8 wel cleared", wel, 0);
    endtask

    task automatic t_done_idle();
        send(8'h06, 8, 1'b0);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 done ignored when idle", wel, 1);
    endtask

    task automatic t_reset_op();
        int o;
        send(8'hD8, 8, 1'b0);
        chk("R9 precondition busy", busy, 1);
        o = n_ok;
        send(8'hFF, 8, 1'b1);
        chk("R9 busy cleared", busy, 0);
        chk("R9 wel cleared", wel, 0);
        chk("R9 ok pulse", n_ok - o, 1);
        chk("R12 so_oe never driven", oe_seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_set_clear();
        t_short_long();
        t_unknown();
        t_gate_locked();
        t_gate_armed();
        t_done_idle();
        t_reset_op();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule